// File: doc/BRIEF.md
# Two-Thread Partitioned Decoupling Queue

This block is an in-order buffer that sits between two pipeline stages and is shared by two hardware threads. In its normal dual-thread arrangement the storage is cut into two equal, fixed halves. Each thread owns one half exclusively and sees a private first-in, first-out queue. Each thread has its own push and pop strobes, its own write data and read data, and its own full and empty flags. One thread's traffic can never take space from the other thread. The read data of each thread always shows the oldest entry of that thread. A pop removes that entry at the next rising clock edge.

A solo-mode request removes the boundary between the halves. The selected thread can then fill every entry. The other thread reports both full and empty, and its pushes are dropped. A three-state mode machine holds the arrangement. Its states are TQ_SPLIT (two halves), TQ_SOLO0 (thread 0 owns all entries) and TQ_SOLO1 (thread 1 owns all entries). The requested arrangement is solo_req_i together with solo_sel_i: request low means TQ_SPLIT, request high with select 0 means TQ_SOLO0, and request high with select 1 means TQ_SOLO1. A transition from the current state to the requested state is taken on a clock edge only when the block is idle. Idle means both threads are empty and no push is presented in that cycle. Until then the old arrangement stays in force. All six transitions between the three states follow this rule. When a transition is taken, the queue pointers restart at zero. Choosing which thread to pop is left to the consumer.

Top module: `tq_split_fifo`

## Requirements
- R1: After reset, both threads report empty (empty_o = 2'b11) and not full (full_o = 2'b00), and the mode is TQ_SPLIT.
- R2: Each thread's entries leave in the order they were pushed. rdataN_o shows that thread's oldest entry whenever empty_o[N] is low.
- R3: In TQ_SPLIT each thread holds at most DEPTH/2 entries. full_o[N] is high exactly when thread N holds DEPTH/2 entries, whatever the other thread holds.
- R4: A push to a thread whose full flag is high is ignored. Nothing is stored, and the thread's occupancy is unchanged.
- R5: A pop from a thread whose empty flag is high is ignored, and that thread's state is unchanged.
- R6: Traffic on one thread never changes the other thread's flags or read data.
- R7: In TQ_SOLO0 or TQ_SOLO1 the selected thread holds up to DEPTH entries and is full only at DEPTH. The unselected thread shows full=1 and empty=1, and its pushes are ignored.
- R8: The mode changes only on a clock edge where both threads are empty and push_i is 2'b00. A request that arrives while entries remain waits until the queue drains.
- R9: A push and a pop on the same thread in the same cycle both take effect when the thread is neither empty nor full. On a full thread only the pop takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| solo_req_i | input | 1 | Request the single-thread arrangement |
| solo_sel_i | input | 1 | Thread that owns the queue in the single-thread arrangement |
| push_i | input | 2 | Push strobe, bit N for thread N |
| wdata0_i | input | WIDTH | Write data of thread 0 |
| wdata1_i | input | WIDTH | Write data of thread 1 |
| pop_i | input | 2 | Pop strobe, bit N for thread N |
| rdata0_o | output | WIDTH | Oldest entry of thread 0 |
| rdata1_o | output | WIDTH | Oldest entry of thread 1 |
| full_o | output | 2 | Full flag, bit N for thread N |
| empty_o | output | 2 | Empty flag, bit N for thread N |

## Verification
A corrupted count or pointer shows on the next cycle as a full or empty flag at the wrong occupancy, or as read data that does not match the oldest value pushed. A mode state that is wrong shows as soon as a thread fills: the boundary appears at DEPTH/2 where DEPTH is expected, or the reverse, or a dropped thread starts accepting pushes. A pointer that runs into the other half shows as foreign data on that thread's read port once the entry reaches the head. The bench therefore compares every flag and every head value on every cycle against a queue model kept per thread.

// File: rtl/tq_pkg.sv
package tq_pkg;
    // Arrangement of the storage between the two threads
    typedef enum logic [1:0] {
        TQ_SPLIT = 2'd0,
        TQ_SOLO0 = 2'd1,
        TQ_SOLO1 = 2'd2
    } tq_mode_e;
endpackage

// File: rtl/tq_mode_fsm.sv
module tq_mode_fsm
    import tq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     solo_req_i,
    input  logic     solo_sel_i,
    input  logic     idle_i,
    output tq_mode_e mode_o,
    output logic     restart_o
);
    tq_mode_e state_q, state_d, target;

    always_comb begin
        if (!solo_req_i)      target = TQ_SPLIT;
        else if (solo_sel_i)  target = TQ_SOLO1;
        else                  target = TQ_SOLO0;
    end

    // next-state logic: every transition is gated by an idle queue
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TQ_SPLIT: if (idle_i && target != TQ_SPLIT) state_d = target;
            TQ_SOLO0: if (idle_i && target != TQ_SOLO0) state_d = target;
            TQ_SOLO1: if (idle_i && target != TQ_SOLO1) state_d = target;
            default:  state_d = TQ_SPLIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TQ_SPLIT;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_o    = state_q;
        restart_o = (state_d != state_q);
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(idle_i));
endmodule

// File: rtl/tq_lane.sv
module tq_lane #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restart_i,
    input  logic                         wide_i,
    input  logic [$clog2(DEPTH+1)-1:0]   cap_i,
    input  logic                         push_i,
    input  logic                         pop_i,
    output logic                         full_o,
    output logic                         empty_o,
    output logic                         push_ok_o,
    output logic [$clog2(DEPTH)-1:0]     wr_ptr_o,
    output logic [$clog2(DEPTH)-1:0]     rd_ptr_o
);
    localparam int HALF = DEPTH / 2;
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = $clog2(DEPTH + 1);

    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic w);
        logic [AW-1:0] lim;
        lim = w ? AW'(DEPTH - 1) : AW'(HALF - 1);
        return (p == lim) ? '0 : p + AW'(1);
    endfunction

    assign full_o    = (cnt_q == cap_i);
    assign empty_o   = (cnt_q == '0);
    assign push_ok_o = push_i && !full_o;
    assign pop_ok    = pop_i && !empty_o;
    assign wr_ptr_o  = wr_q;
    assign rd_ptr_o  = rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (restart_i) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push_ok_o) wr_q <= bump(wr_q, wide_i);
            if (pop_ok)    rd_q <= bump(rd_q, wide_i);
            if (push_ok_o && !pop_ok)      cnt_q <= cnt_q + CW'(1);
            else if (pop_ok && !push_ok_o) cnt_q <= cnt_q - CW'(1);
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cap_i);
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> $stable(cnt_q));
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/tq_store.sv
module tq_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    we_i,
    input  logic [1:0][$clog2(DEPTH)-1:0] wa_i,
    input  logic [1:0][WIDTH-1:0]         wd_i,
    input  logic [1:0][$clog2(DEPTH)-1:0] ra_i,
    output logic [1:0][WIDTH-1:0]         rd_o
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we_i[0] && wa_i[0] == AW'(i))      mem_q[i] <= wd_i[0];
            else if (we_i[1] && wa_i[1] == AW'(i)) mem_q[i] <= wd_i[1];
        end
    end

    for (genvar t = 0; t < 2; t++) begin : g_rd
        assign rd_o[t] = mem_q[ra_i[t]];
    end

    // R6
    port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i[0] && we_i[1] && wa_i[0] == wa_i[1]));
endmodule

// File: rtl/tq_split_fifo.sv
module tq_split_fifo
    import tq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             solo_req_i,
    input  logic             solo_sel_i,
    input  logic [1:0]       push_i,
    input  logic [WIDTH-1:0] wdata0_i,
    input  logic [WIDTH-1:0] wdata1_i,
    input  logic [1:0]       pop_i,
    output logic [WIDTH-1:0] rdata0_o,
    output logic [WIDTH-1:0] rdata1_o,
    output logic [1:0]       full_o,
    output logic [1:0]       empty_o
);
    localparam int HALF = DEPTH / 2;
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = $clog2(DEPTH + 1);

    tq_mode_e             mode;
    logic                 restart, idle;
    logic [1:0]           push_ok;
    logic [1:0][AW-1:0]   wp, rp, wa, ra;
    logic [1:0][WIDTH-1:0] wd, rd;

    assign wd   = {wdata1_i, wdata0_i};
    assign idle = (&empty_o) && (push_i == 2'b00);

    tq_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .solo_req_i (solo_req_i),
        .solo_sel_i (solo_sel_i),
        .idle_i     (idle),
        .mode_o     (mode),
        .restart_o  (restart)
    );

    for (genvar t = 0; t < 2; t++) begin : g_lane
        logic [CW-1:0] cap;
        logic          wide;
        logic [AW-1:0] base;

        always_comb begin
            unique case (mode)
                TQ_SPLIT: begin
                    cap  = CW'(HALF);
                    wide = 1'b0;
                    base = AW'(t * HALF);
                end
                TQ_SOLO0: begin
                    cap  = (t == 0) ? CW'(DEPTH) : '0;
                    wide = 1'b1;
                    base = '0;
                end
                TQ_SOLO1: begin
                    cap  = (t == 1) ? CW'(DEPTH) : '0;
                    wide = 1'b1;
                    base = '0;
                end
                default: begin
                    cap  = '0;
                    wide = 1'b0;
                    base = '0;
                end
            endcase
        end

        tq_lane #(.DEPTH(DEPTH)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart),
            .wide_i    (wide),
            .cap_i     (cap),
            .push_i    (push_i[t]),
            .pop_i     (pop_i[t]),
            .full_o    (full_o[t]),
            .empty_o   (empty_o[t]),
            .push_ok_o (push_ok[t]),
            .wr_ptr_o  (wp[t]),
            .rd_ptr_o  (rp[t])
        );

        assign wa[t] = base + wp[t];
        assign ra[t] = base + rp[t];
    end

    tq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (push_ok),
        .wa_i  (wa),
        .wd_i  (wd),
        .ra_i  (ra),
        .rd_o  (rd)
    );

    assign rdata0_o = rd[0];
    assign rdata1_o = rd[1];

    // R7
    solo_idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TQ_SOLO0) |-> (full_o[1] && empty_o[1]));
endmodule

// File: tb/tq_split_fifo_tb.sv
module tq_split_fifo_tb;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int WIDTH  = 8;
    localparam int HALF   = DEPTH / 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             solo_req = 1'b0, solo_sel = 1'b0;
    logic [1:0]       push = 2'b00, pop = 2'b00;
    logic [WIDTH-1:0] wd0 = '0, wd1 = '0;
    logic [WIDTH-1:0] rd0, rd1;
    logic [1:0]       full, empty;

    int total = 0;
    int bad   = 0;
    int md    = 0;   // 0 split, 1 solo thread 0, 2 solo thread 1
    logic [WIDTH-1:0] q0[$];
    logic [WIDTH-1:0] q1[$];

    always #(PERIOD/2) clk = ~clk;

    tq_split_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .solo_req_i(solo_req), .solo_sel_i(solo_sel),
        .push_i(push), .wdata0_i(wd0), .wdata1_i(wd1), .pop_i(pop),
        .rdata0_o(rd0), .rdata1_o(rd1), .full_o(full), .empty_o(empty)
    );

    function automatic int cap_of(int m, int t);
        if (m == 0) return HALF;
        if (m == t + 1) return DEPTH;
        return 0;
    endfunction

    function automatic int size_of(int t);
        return (t == 0) ? q0.size() : q1.size();
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compare pre-edge outputs, advance model
    task automatic step(logic [1:0] pu, logic [1:0] po, logic sreq, logic ssel, string ph);
        int tgt;
        logic idle;
        logic [WIDTH-1:0] d0, d1;
        @(negedge clk);
        d0 = WIDTH'($urandom);
        d1 = WIDTH'($urandom);
        push = pu; pop = po; solo_req = sreq; solo_sel = ssel; wd0 = d0; wd1 = d1;
        #1;
        for (int t = 0; t < 2; t++) begin
            int sz;
            int ef;
            int ee;
            sz = size_of(t);
            ef = (sz == cap_of(md, t)) ? 1 : 0;
            ee = (sz == 0) ? 1 : 0;
            // R3 in split, R7 in solo; R6 since each lane is checked alone
            chk((md == 0) ? "R3" : "R7", {ph, " full"}, int'(full[t]), ef);
            chk("R5", {ph, " empty"}, int'(empty[t]), ee);
            if (ee == 0) begin
                if (t == 0) chk("R2", {ph, " head0"}, int'(rd0), int'(q0[0]));
                else        chk("R2", {ph, " head1"}, int'(rd1), int'(q1[0]));
            end
        end
        idle = (q0.size() == 0) && (q1.size() == 0) && (pu == 2'b00);
        for (int t = 0; t < 2; t++) begin
            int sz;
            sz = size_of(t);
            if (po[t] && sz != 0) begin
                if (t == 0) void'(q0.pop_front()); else void'(q1.pop_front());
            end
            // R4 / R9: the push is taken only when the lane was not full
            if (pu[t] && sz != cap_of(md, t)) begin
                if (t == 0) q0.push_back(d0); else q1.push_back(d1);
            end
        end
        tgt = !sreq ? 0 : (ssel ? 2 : 1);
        // R8
        if (idle && tgt != md) md = tgt;
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "empty after reset", int'(empty), 3);
        chk("R1", "full after reset", int'(full), 0);

        // R5 pops on empty lanes
        step(2'b00, 2'b11, 0, 0, "R5 pop empty");
        step(2'b00, 2'b00, 0, 0, "R5 after");

        // R4 overfill thread 0, thread 1 idle (R6)
        for (int i = 0; i < HALF + 3; i++) step(2'b01, 2'b00, 0, 0, "R4 overfill");
        // R9 push+pop on a full lane
        step(2'b01, 2'b01, 0, 0, "R9 full");
        step(2'b01, 2'b01, 0, 0, "R9 again");
        step(2'b10, 2'b00, 0, 0, "R6 other");
        for (int i = 0; i < HALF + 2; i++) step(2'b00, 2'b11, 0, 0, "R4 drain");

        // random split traffic
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] pu, po;
            pu = {($urandom % 100) < 55, ($urandom % 100) < 60};
            po = {($urandom % 100) < 45, ($urandom % 100) < 40};
            step(pu, po, 0, 0, "R2 random split");
        end
        for (int i = 0; i < HALF + 1; i++) step(2'b00, 2'b11, 0, 0, "drain");

        // R8: request solo while an entry is held, mode must wait
        step(2'b01, 2'b00, 1, 0, "R8 hold");
        for (int i = 0; i < HALF + 1; i++) step(2'b01, 2'b00, 1, 0, "R8 still split");
        for (int i = 0; i < HALF + 1; i++) step(2'b00, 2'b01, 1, 0, "R8 drain");
        step(2'b00, 2'b00, 1, 0, "R8 switch");

        // R7 solo thread 0 fills the whole queue, thread 1 pushes dropped
        for (int i = 0; i < DEPTH + 2; i++) step(2'b11, 2'b00, 1, 0, "R7 fill");
        for (int i = 0; i < DEPTH + 1; i++) step(2'b10, 2'b11, 1, 0, "R7 drain");

        // R7 solo thread 1 random
        step(2'b00, 2'b00, 1, 1, "R8 to solo1");
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] pu, po;
            pu = {($urandom % 100) < 60, ($urandom % 100) < 50};
            po = {($urandom % 100) < 45, 1'b1};
            step(pu, po, 1, 1, "R7 random solo1");
        end
        for (int i = 0; i < DEPTH + 1; i++) step(2'b00, 2'b11, 0, 0, "drain");
        step(2'b00, 2'b00, 0, 0, "R8 back");
        for (int i = 0; i < HALF + 2; i++) step(2'b11, 2'b00, 0, 0, "R3 refill split");
        for (int i = 0; i < HALF + 1; i++) step(2'b00, 2'b11, 0, 0, "R2 final drain");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule